// File: doc/BRIEF.md
# CAN Controller Register and Interrupt Core

This block holds the control and status register file of a byte-addressed CAN controller. A host reaches it through a chip select, separate read and write strobes, a 5-bit address and an 8-bit data bus. The register map depends on bit 7 of the clock divider register at address 31. When that bit is 0 the block uses a compact basic map. When it is 1 the block uses an extended map, which adds an interrupt enable register and eight acceptance filter bytes.

The block keeps the mode or control register, the status register and the interrupt register for each map. It turns command-register writes into one-cycle strobes for the receive buffer and transmit logic around it. It tracks whether the controller is in reset mode or operating mode, and drives one registered, level-sensitive interrupt line. Receive events enter as single-cycle pulses: a message stored, the last message released, or a data overrun. A level input reports that received messages are still buffered. Receive data bytes come in from the outside buffer through a byte-wide input. Transmit buffer writes leave as a write enable plus a byte index.

Top module: `can_reg_core`

## Requirements
- R1: After hardware reset the basic map is selected (clock divider 0x00). The basic control register reads 0x01, basic status 0x0C and basic interrupt 0x00. After switching to the extended map, mode reads 0x01, status 0x3C and interrupt 0x00. The interrupt output is 0.
- R2: `irq_o` is registered. One clock after the state changes, it equals OR(enable AND pending). In the extended map the enable is the register at address 4. In the basic map, control bits [4:1] enable interrupt bits [3:0].
- R3: A read of address 3 (chip select and read both high) returns the current interrupt value. The register then becomes 0x01 if `rx_pending_i` is high, and 0x00 otherwise.
- R4: A command write (address 1) with bit 0 set pulses `tx_req_o` and sets status bits 2 and 3. It also clears status bit 5 and sets interrupt bit 1. Bit 2 pulses `rx_release_o`.
- R5: A command write with bit 3 set pulses `clr_overrun_o`, clears status bit 1 and clears interrupt bit 3. An `rx_overrun_i` pulse sets both of those bits. `rx_stored_i` sets status bit 0 and interrupt bit 0; `rx_drained_i` clears them.
- R6: Address 1 reads 0x00. Addresses 5 to 15 read 0x00 in the extended map. Addresses with no register read 0xFF.
- R7: A mode or control write keeps only bits [4:0]. When bit 0 goes from 1 to 0, `filt_latch_o` and `rx_clr_o` pulse in the same cycle. A write that finds bit 0 already 0, or leaves it at 1, does not pulse `filt_latch_o`.
- R8: A write to address 16 in the extended map, or address 10 in the basic map, sets status bit 5 in both reset mode and operating mode.
- R9: In the basic map, a control write with bit 0 clear while already in operating mode is a software reset. It pulses `rx_clr_o` and changes the extended map's registers: mode becomes (mode AND 0x0E) OR 0x01, and status becomes (status AND 0xC8) OR 0x34.
- R10: Acceptance bytes sit at extended addresses 16 to 23. They can be written and read back only in reset mode; 24 to 28 read 0x00 there. In operating mode, writes to 16 to 28 (extended) or 10 to 19 (basic) pulse `tx_we_o` with index address−16 or address−10 and leave the acceptance bytes unchanged. Reads of 16 to 28 (extended) or 20 to 29 (basic) return `rx_byte_i`, with `rx_idx_o` set to address−16 or address−20.
- R11: Clock divider bit 7 selects the map. `ext_map_o` reflects it, and `op_mode_o` is the inverse of bit 0 of the selected map's mode or control register.
- R12: The interrupt register is cleared only by a qualified read. A read strobe without chip select leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| rx_byte_i | input | 8 | Byte from the receive buffer at `rx_idx_o` |
| rx_idx_o | output | 5 | Receive window byte index |
| tx_we_o | output | 1 | Transmit buffer byte write enable |
| tx_idx_o | output | 5 | Transmit buffer byte index |
| rx_stored_i | input | 1 | Pulse: a message was stored |
| rx_drained_i | input | 1 | Pulse: the last buffered message was released |
| rx_overrun_i | input | 1 | Pulse: a message was lost to overrun |
| rx_pending_i | input | 1 | Level: at least one message is buffered |
| tx_req_o | output | 1 | Strobe: transmit request |
| rx_release_o | output | 1 | Strobe: release receive buffer |
| clr_overrun_o | output | 1 | Strobe: clear data overrun |
| filt_latch_o | output | 1 | Strobe: latch acceptance filters on entering operating mode |
| rx_clr_o | output | 1 | Strobe: clear receive counters |
| op_mode_o | output | 1 | Operating mode (not reset mode) |
| ext_map_o | output | 1 | Extended register map selected |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets four corner cases.
- **Interrupt read re-arm.** It reads the interrupt register while messages are still buffered. A design that cleared the register outright would drop the receive interrupt with data still waiting.
- **Unqualified read.** It issues a read strobe without chip select. A design that left out the qualification would lose pending interrupts.
- **Mode transition.** It writes mode bit 0 as 0 twice in a row. A design that decoded the write value rather than the 1-to-0 transition would latch filters a second time. It also writes acceptance addresses in operating mode and reads them back after returning to reset mode; a corrupted filter byte would show there.
- **Cross-map software reset.** It checks that a basic-map software reset changes the extended mode and status registers, and that the interrupt line follows its own map's enable placement one cycle after each change.

// File: rtl/can_regs_pkg.sv
package can_regs_pkg;
  localparam int unsigned A_MODE   = 0;
  localparam int unsigned A_CMD    = 1;
  localparam int unsigned A_STAT   = 2;
  localparam int unsigned A_INT    = 3;
  localparam int unsigned A_IER    = 4;
  localparam int unsigned A_CODE   = 4;
  localparam int unsigned A_MASK   = 5;
  localparam int unsigned A_CDR    = 31;
  localparam int unsigned E_ZLO    = 5;
  localparam int unsigned E_ZHI    = 15;
  localparam int unsigned E_WIN_LO = 16;
  localparam int unsigned E_WIN_HI = 28;
  localparam int unsigned E_ACC_HI = 23;
  localparam int unsigned B_TX_LO  = 10;
  localparam int unsigned B_TX_HI  = 19;
  localparam int unsigned B_RX_LO  = 20;
  localparam int unsigned B_RX_HI  = 29;

  localparam logic [7:0] RST_MODE   = 8'h01;
  localparam logic [7:0] RST_STAT_E = 8'h3C;
  localparam logic [7:0] RST_CTRL   = 8'h01;
  localparam logic [7:0] RST_STAT_B = 8'h0C;

  typedef struct packed {
    logic tx;
    logic rel;
    logic clr_ovr;
  } cmd_t;
endpackage

// File: rtl/can_cmd_decode.sv
module can_cmd_decode
  import can_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        cmd_bits_i,  // {bit3, bit2, bit0} of write data
  output cmd_t              cmd_o
);
  logic hit;
  assign hit           = cs_i && wr_i && (32'(addr_i) == A_CMD);
  assign cmd_o.tx      = hit && cmd_bits_i[0];
  assign cmd_o.rel     = hit && cmd_bits_i[1];
  assign cmd_o.clr_ovr = hit && cmd_bits_i[2];
endmodule

// File: rtl/can_acc_regs.sv
module can_acc_regs #(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N-1:0][DATA_W-1:0] bytes_q;

  for (genvar g = 0; g < N; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              bytes_q[g] <= '0;
      else if (we_i && (idx_i == IDX_W'(g)))    bytes_q[g] <= wdata_i;
    end
  end

  assign rdata_o = bytes_q[idx_i];
endmodule

// File: rtl/can_irq_gen.sv
module can_irq_gen #(
  parameter int unsigned EXT_W = 8,
  parameter int unsigned BAS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_i,
  input  logic [EXT_W-1:0] en_ext_i,
  input  logic [EXT_W-1:0] pend_ext_i,
  input  logic [BAS_W-1:0] en_bas_i,
  input  logic [BAS_W-1:0] pend_bas_i,
  output logic             irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= ext_i ? |(en_ext_i & pend_ext_i) : |(en_bas_i & pend_bas_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/can_reg_core.sv
module can_reg_core
  import can_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_N  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic [ADDR_W-1:0] rx_idx_o,
  output logic              tx_we_o,
  output logic [ADDR_W-1:0] tx_idx_o,
  input  logic              rx_stored_i,
  input  logic              rx_drained_i,
  input  logic              rx_overrun_i,
  input  logic              rx_pending_i,
  output logic              tx_req_o,
  output logic              rx_release_o,
  output logic              clr_overrun_o,
  output logic              filt_latch_o,
  output logic              rx_clr_o,
  output logic              op_mode_o,
  output logic              ext_map_o,
  output logic              irq_o
);
  localparam int unsigned ACC_IW = $clog2(ACC_N);

  logic [4:0]        mode_q, mode_d, ctrl_q, ctrl_d;
  logic [DATA_W-1:0] stat_e_q, stat_e_d, int_e_q, int_e_d, ier_q, ier_d, cdr_q, cdr_d;
  logic [DATA_W-1:0] stat_b_q, stat_b_d, int_b_q, int_b_d, code_q, code_d, mask_q, mask_d;
  logic [DATA_W-1:0] acc_rd;
  logic [31:0]       a_w;
  logic              ext, wr_en, rd_en, acc_we, filt, rxclr, txwe;
  cmd_t              cmd;

  assign a_w   = 32'(addr_i);
  assign ext   = cdr_q[7];
  assign wr_en = cs_i && wr_i;
  assign rd_en = cs_i && rd_i && !wr_i;

  can_cmd_decode #(.ADDR_W(ADDR_W)) u_cmd (
    .cs_i       (cs_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .cmd_bits_i ({wdata_i[3], wdata_i[2], wdata_i[0]}),
    .cmd_o      (cmd)
  );

  can_acc_regs #(.N(ACC_N), .DATA_W(DATA_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (acc_we),
    .idx_i   (addr_i[ACC_IW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (acc_rd)
  );

  can_irq_gen #(.EXT_W(DATA_W), .BAS_W(4)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_i      (ext),
    .en_ext_i   (ier_q),
    .pend_ext_i (int_e_q),
    .en_bas_i   (ctrl_q[4:1]),
    .pend_bas_i (int_b_q[3:0]),
    .irq_o      (irq_o)
  );

  always_comb begin
    mode_d = mode_q; ctrl_d = ctrl_q; stat_e_d = stat_e_q; int_e_d = int_e_q;
    ier_d = ier_q; cdr_d = cdr_q; stat_b_d = stat_b_q; int_b_d = int_b_q;
    code_d = code_q; mask_d = mask_q;
    acc_we = 1'b0; filt = 1'b0; rxclr = 1'b0; txwe = 1'b0;

    if (wr_en) begin
      if (a_w == A_CDR) cdr_d = wdata_i;
      else if (ext) begin
        if (a_w == A_MODE) begin
          mode_d = wdata_i[4:0];
          if (mode_q[0] && !wdata_i[0]) begin filt = 1'b1; rxclr = 1'b1; end
        end else if (a_w == A_CMD) begin
          if (cmd.tx) begin
            stat_e_d[3:2] = 2'b11; stat_e_d[5] = 1'b0; int_e_d[1] = 1'b1;
          end
          if (cmd.clr_ovr) begin stat_e_d[1] = 1'b0; int_e_d[3] = 1'b0; end
        end else if (a_w == A_IER) ier_d = wdata_i;
        else if (a_w >= E_WIN_LO && a_w <= E_WIN_HI) begin
          if (a_w == E_WIN_LO) stat_e_d[5] = 1'b1;
          if (mode_q[0]) acc_we = (a_w <= E_ACC_HI);
          else           txwe   = 1'b1;
        end
      end else begin
        if (a_w == A_MODE) begin
          ctrl_d = wdata_i[4:0];
          if (ctrl_q[0] && !wdata_i[0]) begin filt = 1'b1; rxclr = 1'b1; end
          else if (!ctrl_q[0] && !wdata_i[0]) begin
            // software reset acts on the extended-map state
            mode_d   = (mode_q & 5'h0E) | 5'h01;
            stat_e_d = (stat_e_q & 8'hC8) | 8'h34;
            rxclr    = 1'b1;
          end
        end else if (a_w == A_CMD) begin
          if (cmd.tx) begin
            stat_b_d[3:2] = 2'b11; stat_b_d[5] = 1'b0; int_b_d[1] = 1'b1;
          end
          if (cmd.clr_ovr) begin stat_b_d[1] = 1'b0; int_b_d[3] = 1'b0; end
        end else if (a_w == A_CODE) code_d = wdata_i;
        else if (a_w == A_MASK) mask_d = wdata_i;
        else if (a_w >= B_TX_LO && a_w <= B_TX_HI) begin
          if (a_w == B_TX_LO) stat_b_d[5] = 1'b1;
          txwe = !ctrl_q[0];
        end
      end
    end

    if (rd_en && a_w == A_INT) begin
      if (ext) int_e_d = {{(DATA_W-1){1'b0}}, rx_pending_i};
      else     int_b_d = {{(DATA_W-1){1'b0}}, rx_pending_i};
    end

    if (ext) begin
      if (rx_drained_i) begin stat_e_d[0] = 1'b0; int_e_d[0] = 1'b0; end
      if (rx_stored_i)  begin stat_e_d[0] = 1'b1; int_e_d[0] = 1'b1; end
      if (rx_overrun_i) begin stat_e_d[1] = 1'b1; int_e_d[3] = 1'b1; end
    end else begin
      if (rx_drained_i) begin stat_b_d[0] = 1'b0; int_b_d[0] = 1'b0; end
      if (rx_stored_i)  begin stat_b_d[0] = 1'b1; int_b_d[0] = 1'b1; end
      if (rx_overrun_i) begin stat_b_d[1] = 1'b1; int_b_d[3] = 1'b1; end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RST_MODE[4:0];   ctrl_q <= RST_CTRL[4:0];
      stat_e_q <= RST_STAT_E;    int_e_q <= '0;  ier_q <= '0;  cdr_q <= '0;
      stat_b_q <= RST_STAT_B;    int_b_q <= '0;  code_q <= '0; mask_q <= '0;
    end else begin
      mode_q <= mode_d;     ctrl_q <= ctrl_d;
      stat_e_q <= stat_e_d; int_e_q <= int_e_d; ier_q <= ier_d; cdr_q <= cdr_d;
      stat_b_q <= stat_b_d; int_b_q <= int_b_d; code_q <= code_d; mask_q <= mask_d;
    end
  end

  always_comb begin
    rdata_o = '1;
    if (a_w == A_CDR) rdata_o = cdr_q;
    else if (a_w == A_CMD) rdata_o = '0;
    else if (ext) begin
      if (a_w == A_MODE)      rdata_o = {{(DATA_W-5){1'b0}}, mode_q};
      else if (a_w == A_STAT) rdata_o = stat_e_q;
      else if (a_w == A_INT)  rdata_o = int_e_q;
      else if (a_w == A_IER)  rdata_o = ier_q;
      else if (a_w >= E_ZLO && a_w <= E_ZHI) rdata_o = '0;
      else if (a_w >= E_WIN_LO && a_w <= E_WIN_HI) begin
        if (!mode_q[0])             rdata_o = rx_byte_i;
        else if (a_w <= E_ACC_HI)   rdata_o = acc_rd;
        else                        rdata_o = '0;
      end
    end else begin
      if (a_w == A_MODE)      rdata_o = {{(DATA_W-5){1'b0}}, ctrl_q};
      else if (a_w == A_STAT) rdata_o = stat_b_q;
      else if (a_w == A_INT)  rdata_o = int_b_q;
      else if (a_w == A_CODE) rdata_o = code_q;
      else if (a_w == A_MASK) rdata_o = mask_q;
      else if (a_w >= B_RX_LO && a_w <= B_RX_HI) rdata_o = rx_byte_i;
    end
  end

  assign rx_idx_o      = ext ? addr_i - ADDR_W'(E_WIN_LO) : addr_i - ADDR_W'(B_RX_LO);
  assign tx_idx_o      = ext ? addr_i - ADDR_W'(E_WIN_LO) : addr_i - ADDR_W'(B_TX_LO);
  assign tx_we_o       = txwe;
  assign tx_req_o      = cmd.tx;
  assign rx_release_o  = cmd.rel;
  assign clr_overrun_o = cmd.clr_ovr;
  assign filt_latch_o  = filt;
  assign rx_clr_o      = rxclr;
  assign ext_map_o     = ext;
  assign op_mode_o     = ext ? !mode_q[0] : !ctrl_q[0];
endmodule

// File: rtl/can_reg_core_chk.sv
module can_reg_core_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rx_stored_i,
  input logic              rx_drained_i,
  input logic              rx_overrun_i,
  input logic              rx_pending_i,
  input logic              tx_req_o,
  input logic              clr_overrun_o,
  input logic              filt_latch_o,
  input logic              rx_clr_o,
  input logic              ext_map_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] int_e_q,
  input logic [3:0]        int_b_lo,
  input logic [DATA_W-1:0] ier_q,
  input logic [3:0]        ctrl_en
);
  a_r4_tx_sets_int_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_map_o && tx_req_o) |=> int_e_q[1]);
  a_r4_tx_sets_int_bas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_map_o && tx_req_o) |=> int_b_lo[1]);
  a_r5_clear_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_map_o && clr_overrun_o && !rx_overrun_i) |=> !int_e_q[3]);
  a_r3_read_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && !wr_i && 32'(addr_i) == 3 && ext_map_o &&
     !rx_stored_i && !rx_drained_i && !rx_overrun_i)
    |=> (int_e_q == {{(DATA_W-1){1'b0}}, $past(rx_pending_i)}));
  a_r6_cmd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) == 1) |-> (rdata_o == '0));
  a_r7_latch_clears_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_latch_o |-> rx_clr_o);
  a_r2_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ext_map_o ? |(ier_q & int_e_q) : |(ctrl_en & int_b_lo)));
  a_r12_no_silent_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(cs_i && rd_i) && !(cs_i && wr_i) && !rx_drained_i && ext_map_o)
    |=> ((int_e_q & $past(int_e_q)) == $past(int_e_q)));
endmodule

bind can_reg_core can_reg_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .wr_i(wr_i), .rd_i(rd_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .rx_stored_i(rx_stored_i),
  .rx_drained_i(rx_drained_i), .rx_overrun_i(rx_overrun_i),
  .rx_pending_i(rx_pending_i), .tx_req_o(tx_req_o), .clr_overrun_o(clr_overrun_o),
  .filt_latch_o(filt_latch_o), .rx_clr_o(rx_clr_o), .ext_map_o(ext_map_o),
  .irq_o(irq_o), .int_e_q(int_e_q), .int_b_lo(int_b_q[3:0]), .ier_q(ier_q),
  .ctrl_en(ctrl_q[4:1])
);

// File: tb/can_reg_core_tb.sv
module can_reg_core_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs = 0, wr = 0, rd = 0, st = 0, dr = 0, ov = 0, pend = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rx_byte = 8'hA5;
  logic [7:0] rdata;
  logic [4:0] rx_idx, tx_idx;
  logic tx_we, tx_req, rel, clro, filt, rxclr, opm, extm, irq;

  int n_cmp = 0, n_bad = 0;

  logic [7:0] m_mode, m_se, m_ie, m_ier, m_cdr, m_ctrl, m_sb, m_ib, m_code, m_mask;
  logic [7:0] m_acc [8];
  logic       m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_reg_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_byte_i(rx_byte), .rx_idx_o(rx_idx),
    .tx_we_o(tx_we), .tx_idx_o(tx_idx), .rx_stored_i(st), .rx_drained_i(dr),
    .rx_overrun_i(ov), .rx_pending_i(pend), .tx_req_o(tx_req), .rx_release_o(rel),
    .clr_overrun_o(clro), .filt_latch_o(filt), .rx_clr_o(rxclr), .op_mode_o(opm),
    .ext_map_o(extm), .irq_o(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(int a);
    if (a == 31) return m_cdr;
    if (a == 1)  return 8'h00;
    if (m_cdr[7]) begin
      if (a == 0) return m_mode;
      if (a == 2) return m_se;
      if (a == 3) return m_ie;
      if (a == 4) return m_ier;
      if (a >= 5 && a <= 15) return 8'h00;
      if (a >= 16 && a <= 28) begin
        if (!m_mode[0]) return rx_byte;
        return (a <= 23) ? m_acc[a-16] : 8'h00;
      end
      return 8'hFF;
    end
    if (a == 0) return m_ctrl;
    if (a == 2) return m_sb;
    if (a == 3) return m_ib;
    if (a == 4) return m_code;
    if (a == 5) return m_mask;
    if (a >= 20 && a <= 29) return rx_byte;
    return 8'hFF;
  endfunction

  function automatic logic irq_now();
    if (m_cdr[7]) return |(m_ier & m_ie);
    return |(m_ctrl[4:1] & m_ib[3:0]);
  endfunction

  task automatic model_reset();
    m_mode = 8'h01; m_se = 8'h3C; m_ie = 0; m_ier = 0; m_cdr = 0;
    m_ctrl = 8'h01; m_sb = 8'h0C; m_ib = 0; m_code = 0; m_mask = 0; m_irq = 0;
    foreach (m_acc[i]) m_acc[i] = 0;
  endtask

  task automatic model_step(logic c, logic w, logic r, int a, logic [7:0] v,
                            logic s, logic d, logic o, logic p);
    logic ex;
    ex = m_cdr[7];
    if (c && w) begin
      if (a == 31) m_cdr = v;
      else if (ex) begin
        case (a)
          0: m_mode = v & 8'h1F;
          1: begin
            if (v[0]) begin m_se = (m_se | 8'h0C) & 8'hDF; m_ie = m_ie | 8'h02; end
            if (v[3]) begin m_se = m_se & 8'hFD; m_ie = m_ie & 8'hF7; end
          end
          4: m_ier = v;
          default: if (a >= 16 && a <= 28) begin
            if (a == 16) m_se = m_se | 8'h20;
            if (m_mode[0] && a <= 23) m_acc[a-16] = v;
          end
        endcase
      end else begin
        case (a)
          0: begin
            if (!m_ctrl[0] && !v[0]) begin
              m_mode = (m_mode & 8'h0E) | 8'h01;
              m_se   = (m_se & 8'hC8) | 8'h34;
            end
            m_ctrl = v & 8'h1F;
          end
          1: begin
            if (v[0]) begin m_sb = (m_sb | 8'h0C) & 8'hDF; m_ib = m_ib | 8'h02; end
            if (v[3]) begin m_sb = m_sb & 8'hFD; m_ib = m_ib & 8'hF7; end
          end
          4: m_code = v;
          5: m_mask = v;
          default: if (a == 10) m_sb = m_sb | 8'h20;
        endcase
      end
    end
    if (c && r && !w && a == 3) begin
      if (ex) m_ie = {7'd0, p}; else m_ib = {7'd0, p};
    end
    if (ex) begin
      if (d) begin m_se[0] = 0; m_ie[0] = 0; end
      if (s) begin m_se[0] = 1; m_ie[0] = 1; end
      if (o) begin m_se[1] = 1; m_ie[3] = 1; end
    end else begin
      if (d) begin m_sb[0] = 0; m_ib[0] = 0; end
      if (s) begin m_sb[0] = 1; m_ib[0] = 1; end
      if (o) begin m_sb[1] = 1; m_ib[3] = 1; end
    end
  endtask

  // One bus cycle: drive at negedge, check outputs, advance model after posedge.
  task automatic cyc(string req, logic c, logic w, logic r, int a, logic [7:0] v,
                     logic s = 0, logic d = 0, logic o = 0);
    logic ex, mb, e_filt, e_rxclr, e_txwe;
    @(negedge clk);
    cs = c; wr = w; rd = r; addr = 5'(a); wdata = v; st = s; dr = d; ov = o;
    #1;
    ex = m_cdr[7];
    mb = ex ? m_mode[0] : m_ctrl[0];
    e_filt  = c && w && a == 0 && mb && !v[0];
    e_rxclr = e_filt || (c && w && a == 0 && !ex && !m_ctrl[0] && !v[0]);
    e_txwe  = c && w && !mb && (ex ? (a >= 16 && a <= 28) : (a >= 10 && a <= 19));
    chk("R2", "irq_o", irq, m_irq);
    chk("R11", "ext_map_o", extm, ex);
    chk("R11", "op_mode_o", opm, !mb);
    chk("R4", "tx_req_o", tx_req, c && w && a == 1 && v[0]);
    chk("R4", "rx_release_o", rel, c && w && a == 1 && v[2]);
    chk("R5", "clr_overrun_o", clro, c && w && a == 1 && v[3]);
    chk("R7", "filt_latch_o", filt, e_filt);
    chk((!ex && !m_ctrl[0]) ? "R9" : "R7", "rx_clr_o", rxclr, e_rxclr);
    chk("R10", "tx_we_o", tx_we, e_txwe);
    if (e_txwe) chk("R10", "tx_idx_o", tx_idx, ex ? a - 16 : a - 10);
    if (c && r) begin
      chk(req, $sformatf("rdata @%0d", a), rdata, exp_rd(a));
      if (ex ? (!m_mode[0] && a >= 16 && a <= 28) : (a >= 20 && a <= 29))
        chk("R10", "rx_idx_o", rx_idx, ex ? a - 16 : a - 20);
    end
    @(posedge clk);
    #1;
    m_irq = irq_now();
    model_step(c, w, r, a, v, s, d, o, pend);
  endtask

  task automatic wr_reg(string req, int a, logic [7:0] v); cyc(req, 1, 1, 0, a, v); endtask
  task automatic rd_reg(string req, int a);                cyc(req, 1, 0, 1, a, 8'h00); endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc("R2", 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 basic-map reset values; R6 read values
    rd_reg("R1", 0); rd_reg("R1", 2); rd_reg("R1", 3); rd_reg("R1", 31);
    rd_reg("R6", 1); rd_reg("R6", 7); rd_reg("R6", 12);

    // basic map, reset mode
    wr_reg("R1", 4, 8'h5A); wr_reg("R1", 5, 8'hC3);
    rd_reg("R1", 4); rd_reg("R1", 5);
    wr_reg("R8", 10, 8'h11); rd_reg("R8", 2);        // stat bit 5, no tx_we
    wr_reg("R7", 0, 8'hFF);  rd_reg("R7", 0);        // keeps 0x1F, still reset
    wr_reg("R7", 0, 8'h1E);  rd_reg("R7", 0);        // enter operating: latch
    wr_reg("R10", 11, 8'h22); wr_reg("R10", 19, 8'h23);
    rd_reg("R10", 20); rd_reg("R10", 29);
    wr_reg("R4", 1, 8'h05); idle(2);                 // tx + release
    rd_reg("R4", 2); rd_reg("R3", 3); idle(2);       // read clears, irq drops
    pend = 1; cyc("R5", 0, 0, 0, 0, 8'h00, 1, 0, 0); idle(1);
    rd_reg("R3", 3); rd_reg("R3", 3); idle(1);       // re-armed receive bit
    cyc("R5", 0, 0, 0, 0, 8'h00, 0, 0, 1); idle(1); rd_reg("R5", 2);
    wr_reg("R5", 1, 8'h08); rd_reg("R5", 2); rd_reg("R5", 3);
    pend = 0; cyc("R5", 0, 0, 0, 0, 8'h00, 0, 1, 0); rd_reg("R5", 2); idle(1);

    // extended map
    wr_reg("R11", 31, 8'h80);
    rd_reg("R1", 0); rd_reg("R1", 2); rd_reg("R1", 3); rd_reg("R11", 31);
    rd_reg("R6", 1); rd_reg("R6", 5); rd_reg("R6", 15); rd_reg("R6", 29);
    for (int i = 16; i <= 23; i++) wr_reg("R10", i, 8'(8'h30 + i));
    wr_reg("R10", 26, 8'h99);
    rd_reg("R10", 16); rd_reg("R10", 19); rd_reg("R10", 23); rd_reg("R10", 26);
    wr_reg("R7", 0, 8'hFE); rd_reg("R7", 0);         // latch, keeps 0x1E
    wr_reg("R7", 0, 8'h1E);                          // no second latch
    rd_reg("R10", 17); rd_reg("R10", 28);
    wr_reg("R10", 18, 8'h77);                        // tx buffer, not acc
    wr_reg("R8", 16, 8'h01); rd_reg("R8", 2);
    wr_reg("R4", 1, 8'h01); rd_reg("R4", 2); idle(2);  // ier 0: no irq
    wr_reg("R2", 4, 8'h02); idle(3);                  // irq rises after enable
    cyc("R12", 0, 0, 1, 3, 8'h00); idle(1);           // unqualified read
    wr_reg("R2", 4, 8'h0B); rd_reg("R12", 3); idle(2);
    rd_reg("R3", 3); idle(1);
    pend = 1; cyc("R5", 0, 0, 0, 0, 8'h00, 1, 0, 1); idle(2);
    rd_reg("R3", 3); rd_reg("R3", 3); rd_reg("R5", 2);
    wr_reg("R5", 1, 8'h08); idle(1); rd_reg("R5", 3);
    pend = 0; cyc("R5", 0, 0, 0, 0, 8'h00, 0, 1, 0); idle(2);
    wr_reg("R10", 0, 8'h01); rd_reg("R10", 18); rd_reg("R10", 22);
    wr_reg("R9", 0, 8'h11);                           // stays reset, bit4 set
    cyc("R9", 0, 0, 0, 0, 8'h00, 1, 0, 0);            // status bit 0 set

    // basic-map software reset acting on extended registers
    wr_reg("R11", 31, 8'h00);
    wr_reg("R9", 0, 8'h1E);                           // ctrl already operating
    wr_reg("R11", 31, 8'h80);
    rd_reg("R9", 0); rd_reg("R9", 2);
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule